// File: doc/BRIEF.md
# Control Endpoint OUT Receive Buffer

This block holds the data stage of OUT transfers on a USB control endpoint. A serial engine hands it the bytes of each OUT data packet, framed by start and end strobes and a good/bad verdict. The block stores up to 64 bytes in a single buffer and counts them. It then decides which handshake the serial engine should return, raises a receive-complete flag and publishes the byte count. Setup packets never reach this buffer. The serial engine only reports that one arrived, and that report locks out OUT data until firmware acknowledges it.

The CPU side drains the buffer through a 32-bit read port, four bytes per read, oldest byte in the least significant lane. Firmware then clears the receive-complete flag. This releases the buffer for the next packet and rewinds the read pointer. While the flag is set, new packets are turned away with NAK so unread data is never overwritten.

Top module: `ep0o_rx_fifo`

## Requirements
- R1: After a synchronous reset, `rx_done`, `rx_size`, `hs_valid` and `rd_valid` are all 0.
- R2: An accepted good packet of N bytes, with 1 <= N <= 64, sets `rx_done` to 1 and `rx_size` to N in the cycle after `rx_eop`. Exactly 64 bytes is still accepted.
- R3: `hs_valid` pulses for one cycle in the cycle after every `rx_eop` of a packet opened by `rx_sop`. For an accepted non-empty good packet, `hs_code` is 3 (NYET) when `hs_mode`=1 (high speed) and 1 (ACK) when `hs_mode`=0 (full speed).
- R4: A good zero-length packet is answered with `hs_code`=1 (ACK) in both speed modes. It sets `rx_done` to 1 and `rx_size` to 0.
- R5: A packet that starts while `rx_done` is 1 is answered with `hs_code`=2 (NAK). It leaves `rx_done`, `rx_size` and the stored bytes unchanged.
- R6: After a `setup_seen` pulse, every OUT packet is answered with `hs_code`=2 (NAK) and nothing is stored or flagged. This lasts until a `setup_clr` pulse, after which packets are accepted again.
- R7: A packet with more than 64 bytes, or one ending with `rx_good`=0, is answered with `hs_code`=0 (no handshake). `rx_done` and `rx_size` keep their previous values.
- R8: A `rd_en` pulse gives `rd_valid`=1 and the next buffer word on `rd_data` one cycle later. Byte k of the packet appears at bits [8*(k%4)+7 : 8*(k%4)], and consecutive reads advance by four bytes.
- R9: A `clr_flag` pulse clears `rx_done` in the next cycle and rewinds the read pointer, so the next read returns bytes 0 to 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| hs_mode | input | 1 | 1 = high-speed bus, 0 = full-speed bus |
| setup_seen | input | 1 | Pulse: a setup packet was received |
| setup_clr | input | 1 | Pulse: firmware cleared the setup-complete condition |
| rx_sop | input | 1 | Pulse: an OUT data packet begins |
| rx_valid | input | 1 | A data byte is present on `rx_data` |
| rx_data | input | 8 | Received data byte |
| rx_eop | input | 1 | Pulse: packet ended (no byte in the same cycle) |
| rx_good | input | 1 | Packet verdict from the serial engine, sampled with `rx_eop` |
| hs_valid | output | 1 | Handshake decision valid |
| hs_code | output | 2 | 0 none, 1 ACK, 2 NAK, 3 NYET |
| rx_done | output | 1 | Receive-complete flag |
| rx_size | output | 7 | Byte count of the last accepted packet |
| clr_flag | input | 1 | Pulse: firmware clears `rx_done` and releases the buffer |
| rd_en | input | 1 | Read one 32-bit word |
| rd_data | output | 32 | Read data, little-endian byte order |
| rd_valid | output | 1 | `rd_data` holds the word requested one cycle earlier |

## Verification
The main function is tried with a table of packets that differ in length (0, 1, 4, 17, 64, 65 bytes), speed mode and verdict. The speed-mode pairs separate NYET from ACK. The zero-length pair shows that an empty packet overrides the speed choice. The 64/65 pair places the overflow edge exactly. Directed cases then send a packet onto a full buffer and onto a setup lock, and read the buffer afterwards to prove nothing was overwritten. A partial read followed by a flag clear shows that the pointer rewinds.

// File: rtl/ep0o_pkg.sv
package ep0o_pkg;
  typedef enum logic [1:0] {
    HS_NONE = 2'd0,
    HS_ACK  = 2'd1,
    HS_NAK  = 2'd2,
    HS_NYET = 2'd3
  } hs_code_e;
endpackage

// File: rtl/ep0o_lane_ram.sv
module ep0o_lane_ram #(
  parameter int DW    = 8,
  parameter int WORDS = 16,
  localparam int AW   = $clog2(WORDS)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic          re,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  logic [DW-1:0] mem [WORDS];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (rst)     rdata <= '0;
    else if (re) rdata <= mem[raddr];
  end
endmodule

// File: rtl/ep0o_rx_ctrl.sv
module ep0o_rx_ctrl
  import ep0o_pkg::*;
#(
  parameter int DEPTH = 64,
  localparam int AW   = $clog2(DEPTH),
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          hs_mode,
  input  logic          setup_seen,
  input  logic          setup_clr,
  input  logic          rx_sop,
  input  logic          rx_valid,
  input  logic          rx_eop,
  input  logic          rx_good,
  input  logic          clr_flag,
  output logic          wr_en,
  output logic [AW-1:0] wr_addr,
  output logic          hs_valid,
  output hs_code_e      hs_code,
  output logic          rx_done,
  output logic [CW-1:0] rx_size
);
  logic          in_pkt_q;
  logic          acc_q;
  logic          ovf_q;
  logic          lock_q;
  logic [CW-1:0] len_q;
  logic          full_w;

  assign full_w  = (len_q == CW'(DEPTH));
  assign wr_en   = in_pkt_q && acc_q && rx_valid && !full_w;
  assign wr_addr = len_q[AW-1:0];

  always_ff @(posedge clk) begin
    if (rst) begin
      in_pkt_q <= 1'b0;
      acc_q    <= 1'b0;
      ovf_q    <= 1'b0;
      lock_q   <= 1'b0;
      len_q    <= '0;
      hs_valid <= 1'b0;
      hs_code  <= HS_NONE;
      rx_done  <= 1'b0;
      rx_size  <= '0;
    end else begin
      hs_valid <= 1'b0;
      if (setup_seen)     lock_q <= 1'b1;
      else if (setup_clr) lock_q <= 1'b0;
      if (clr_flag) rx_done <= 1'b0;
      if (rx_sop) begin
        in_pkt_q <= 1'b1;
        acc_q    <= !rx_done && !lock_q;
        ovf_q    <= 1'b0;
        len_q    <= '0;
      end else if (in_pkt_q) begin
        if (rx_valid) begin
          if (full_w) ovf_q <= 1'b1;
          else        len_q <= len_q + CW'(1);
        end
        if (rx_eop) begin
          in_pkt_q <= 1'b0;
          hs_valid <= 1'b1;
          if (!acc_q) begin
            hs_code <= HS_NAK;
          end else if (!rx_good || ovf_q) begin
            hs_code <= HS_NONE;
          end else begin
            if (len_q == '0)  hs_code <= HS_ACK;
            else if (hs_mode) hs_code <= HS_NYET;
            else              hs_code <= HS_ACK;
            rx_done <= 1'b1;
            rx_size <= len_q;
          end
        end
      end
    end
  end

  AST_SIZE_LIMIT: assert property (@(posedge clk) disable iff (rst)
    rx_size <= CW'(DEPTH)); // R2

  AST_NYET_ONLY_HS: assert property (@(posedge clk) disable iff (rst)
    (hs_valid && hs_code == HS_NYET) |-> $past(hs_mode)); // R3

  AST_NYET_NONEMPTY: assert property (@(posedge clk) disable iff (rst)
    (hs_valid && hs_code == HS_NYET) |-> (rx_done && rx_size != '0)); // R4

  AST_NAK_WHEN_REFUSED: assert property (@(posedge clk) disable iff (rst)
    (in_pkt_q && !acc_q && rx_eop && !rx_sop) |=> (hs_valid && hs_code == HS_NAK)); // R5

  AST_SIZE_STABLE_NAK: assert property (@(posedge clk) disable iff (rst)
    (hs_valid && hs_code != HS_ACK && hs_code != HS_NYET) |-> $stable(rx_size)); // R7

  AST_DONE_HOLD: assert property (@(posedge clk) disable iff (rst)
    (rx_done && !clr_flag) |=> rx_done); // R9
endmodule

// File: rtl/ep0o_cpu_port.sv
module ep0o_cpu_port #(
  parameter int WORDS = 16,
  localparam int WAW  = $clog2(WORDS)
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           rd_en,
  input  logic           clr_flag,
  output logic           ram_re,
  output logic [WAW-1:0] ram_raddr,
  output logic           rd_valid
);
  logic [WAW-1:0] ptr_q;

  assign ram_re    = rd_en;
  assign ram_raddr = ptr_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      ptr_q    <= '0;
      rd_valid <= 1'b0;
    end else begin
      rd_valid <= rd_en;
      if (clr_flag)   ptr_q <= '0;
      else if (rd_en) ptr_q <= ptr_q + WAW'(1);
    end
  end

  AST_PTR_REWIND: assert property (@(posedge clk) disable iff (rst)
    clr_flag |=> (ptr_q == '0)); // R9

  AST_RDV_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
    rd_en |=> rd_valid); // R8

  AST_RDV_ONLY_AFTER_RD: assert property (@(posedge clk) disable iff (rst)
    rd_valid |-> $past(rd_en)); // R8
endmodule

// File: rtl/ep0o_rx_fifo.sv
module ep0o_rx_fifo
  import ep0o_pkg::*;
#(
  parameter int DEPTH  = 64,
  parameter int BYTE_W = 8,
  parameter int BUS_W  = 32
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         hs_mode,
  input  logic                         setup_seen,
  input  logic                         setup_clr,
  input  logic                         rx_sop,
  input  logic                         rx_valid,
  input  logic [BYTE_W-1:0]            rx_data,
  input  logic                         rx_eop,
  input  logic                         rx_good,
  output logic                         hs_valid,
  output logic [1:0]                   hs_code,
  output logic                         rx_done,
  output logic [$clog2(DEPTH+1)-1:0]   rx_size,
  input  logic                         clr_flag,
  input  logic                         rd_en,
  output logic [BUS_W-1:0]             rd_data,
  output logic                         rd_valid
);
  localparam int LANES = BUS_W / BYTE_W;
  localparam int WORDS = DEPTH / LANES;
  localparam int AW    = $clog2(DEPTH);
  localparam int LW    = $clog2(LANES);
  localparam int WAW   = $clog2(WORDS);

  logic           wr_en;
  logic [AW-1:0]  wr_addr;
  logic           ram_re;
  logic [WAW-1:0] ram_raddr;
  hs_code_e       hs_code_w;

  ep0o_rx_ctrl #(.DEPTH(DEPTH)) u_ctrl (
    .clk        (clk),
    .rst        (rst),
    .hs_mode    (hs_mode),
    .setup_seen (setup_seen),
    .setup_clr  (setup_clr),
    .rx_sop     (rx_sop),
    .rx_valid   (rx_valid),
    .rx_eop     (rx_eop),
    .rx_good    (rx_good),
    .clr_flag   (clr_flag),
    .wr_en      (wr_en),
    .wr_addr    (wr_addr),
    .hs_valid   (hs_valid),
    .hs_code    (hs_code_w),
    .rx_done    (rx_done),
    .rx_size    (rx_size)
  );

  assign hs_code = hs_code_w;

  ep0o_cpu_port #(.WORDS(WORDS)) u_cpu (
    .clk       (clk),
    .rst       (rst),
    .rd_en     (rd_en),
    .clr_flag  (clr_flag),
    .ram_re    (ram_re),
    .ram_raddr (ram_raddr),
    .rd_valid  (rd_valid)
  );

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic lane_we;
    assign lane_we = wr_en && (wr_addr[LW-1:0] == LW'(g));
    ep0o_lane_ram #(.DW(BYTE_W), .WORDS(WORDS)) u_ram (
      .clk   (clk),
      .rst   (rst),
      .we    (lane_we),
      .waddr (wr_addr[AW-1:LW]),
      .wdata (rx_data),
      .re    (ram_re),
      .raddr (ram_raddr),
      .rdata (rd_data[g*BYTE_W +: BYTE_W])
    );
  end
endmodule

// File: tb/ep0o_rx_fifo_tb.sv
module ep0o_rx_fifo_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        hs_mode = 1'b0, setup_seen = 1'b0, setup_clr = 1'b0;
  logic        rx_sop = 1'b0, rx_valid = 1'b0, rx_eop = 1'b0, rx_good = 1'b0;
  logic [7:0]  rx_data = '0;
  logic        clr_flag = 1'b0, rd_en = 1'b0;
  logic        hs_valid, rx_done, rd_valid;
  logic [1:0]  hs_code;
  logic [6:0]  rx_size;
  logic [31:0] rd_data;

  int n_tests = 0;
  int n_fail  = 0;

  always #4 clk = ~clk;

  ep0o_rx_fifo u_dut (
    .clk(clk), .rst(rst), .hs_mode(hs_mode), .setup_seen(setup_seen),
    .setup_clr(setup_clr), .rx_sop(rx_sop), .rx_valid(rx_valid),
    .rx_data(rx_data), .rx_eop(rx_eop), .rx_good(rx_good),
    .hs_valid(hs_valid), .hs_code(hs_code), .rx_done(rx_done),
    .rx_size(rx_size), .clr_flag(clr_flag), .rd_en(rd_en),
    .rd_data(rd_data), .rd_valid(rd_valid)
  );

  // fields: [18:12] len, [11] hs_mode, [10] good, [9:8] code, [7] done, [6:0] size
  localparam logic [18:0] VEC [8] = '{
    {7'd1,  1'b0, 1'b1, 2'd1, 1'b1, 7'd1},
    {7'd4,  1'b1, 1'b1, 2'd3, 1'b1, 7'd4},
    {7'd64, 1'b1, 1'b1, 2'd3, 1'b1, 7'd64},
    {7'd0,  1'b1, 1'b1, 2'd1, 1'b1, 7'd0},
    {7'd65, 1'b0, 1'b1, 2'd0, 1'b0, 7'd0},
    {7'd10, 1'b1, 1'b0, 2'd0, 1'b0, 7'd0},
    {7'd17, 1'b0, 1'b1, 2'd1, 1'b1, 7'd17},
    {7'd0,  1'b0, 1'b1, 2'd1, 1'b1, 7'd0}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic send_pkt(input int len, input logic [7:0] seed, input bit good,
                          input bit mode, output logic hv, output logic [1:0] hc);
    @(negedge clk);
    hs_mode = mode;
    rx_sop  = 1'b1;
    @(negedge clk);
    rx_sop = 1'b0;
    for (int i = 0; i < len; i++) begin
      rx_valid = 1'b1;
      rx_data  = seed + 8'(i);
      @(negedge clk);
    end
    rx_valid = 1'b0;
    rx_eop   = 1'b1;
    rx_good  = good;
    @(negedge clk);
    rx_eop = 1'b0;
    hv = hs_valid;
    hc = hs_code;
  endtask

  task automatic pulse_clr();
    @(negedge clk); clr_flag = 1'b1;
    @(negedge clk); clr_flag = 1'b0;
  endtask

  task automatic read_word(output logic [31:0] d, output logic v);
    @(negedge clk); rd_en = 1'b1;
    @(negedge clk); rd_en = 1'b0;
    d = rd_data;
    v = rd_valid;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    logic        hv, v;
    logic [1:0]  hc;
    logic [31:0] d;

    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk("R1 rx_done", 32'(rx_done), 0);
    chk("R1 rx_size", 32'(rx_size), 0);
    chk("R1 hs_valid", 32'(hs_valid), 0);
    chk("R1 rd_valid", 32'(rd_valid), 0);

    // table walk
    for (int vi = 0; vi < 8; vi++) begin
      int          len;
      logic [7:0]  seed;
      string       tag;
      len  = int'(VEC[vi][18:12]);
      seed = 8'(8'h11 * (vi + 1));
      if (len == 0)                     tag = "R4";
      else if (!VEC[vi][10] || len > 64) tag = "R7";
      else                              tag = "R3";
      pulse_clr();
      send_pkt(len, seed, VEC[vi][10], VEC[vi][11], hv, hc);
      chk({tag, " hs_valid"}, 32'(hv), 1);
      chk({tag, " hs_code"}, 32'(hc), 32'(VEC[vi][9:8]));
      chk({tag == "R3" ? "R2" : tag, " rx_done"}, 32'(rx_done), 32'(VEC[vi][7]));
      chk({tag == "R3" ? "R2" : tag, " rx_size"}, 32'(rx_size), 32'(VEC[vi][6:0]));
      if (VEC[vi][7] && len > 0) begin
        for (int w = 0; w < (len + 3) / 4; w++) begin
          logic [31:0] exp, msk;
          exp = '0; msk = '0;
          for (int b = 0; b < 4; b++) begin
            if (w * 4 + b < len) begin
              exp[b*8 +: 8] = seed + 8'(w * 4 + b);
              msk[b*8 +: 8] = 8'hff;
            end
          end
          read_word(d, v);
          chk("R8 rd_valid", 32'(v), 1);
          chk("R8 rd_data", d & msk, exp);
        end
      end
    end

    // R9: partial read, clear, new packet starts from byte 0
    pulse_clr();
    send_pkt(8, 8'h40, 1'b1, 1'b0, hv, hc);
    read_word(d, v);
    chk("R8 first word", d, 32'h43424140);
    pulse_clr();
    chk("R9 rx_done cleared", 32'(rx_done), 0);
    send_pkt(4, 8'h60, 1'b1, 1'b0, hv, hc);
    chk("R9 accepted after clear", 32'(hc), 1);

    // R5: buffer busy -> NAK, data and size kept
    send_pkt(6, 8'h90, 1'b1, 1'b1, hv, hc);
    chk("R5 hs_code NAK", 32'(hc), 2);
    chk("R5 rx_size kept", 32'(rx_size), 4);
    chk("R5 rx_done kept", 32'(rx_done), 1);
    read_word(d, v);
    chk("R5 R9 data kept and pointer rewound", d, 32'h63626160);

    // R6: setup lock
    @(negedge clk); setup_seen = 1'b1;
    @(negedge clk); setup_seen = 1'b0;
    pulse_clr();
    send_pkt(3, 8'hA0, 1'b1, 1'b1, hv, hc);
    chk("R6 hs_code NAK under lock", 32'(hc), 2);
    chk("R6 rx_done not set", 32'(rx_done), 0);
    chk("R6 rx_size kept", 32'(rx_size), 4);
    send_pkt(0, 8'h00, 1'b1, 1'b0, hv, hc);
    chk("R6 zero-length NAK under lock", 32'(hc), 2);
    @(negedge clk); setup_clr = 1'b1;
    @(negedge clk); setup_clr = 1'b0;
    send_pkt(3, 8'hB0, 1'b1, 1'b1, hv, hc);
    chk("R6 NYET after unlock", 32'(hc), 3);
    chk("R6 rx_size after unlock", 32'(rx_size), 3);
    read_word(d, v);
    chk("R6 data after unlock", d & 32'h00ffffff, 32'h00b2b1b0);

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule